// File: doc/BRIEF.md
# SIMD Halfword Multiply-Low-Add Unit

This execution unit accepts one 32-bit vector instruction per clock and performs a packed multiply-low-add on halfwords. It holds a 32-entry file of 128-bit vector registers. For a recognised instruction, it reads three source registers and splits each into eight 16-bit lanes. In every lane it keeps the low 16 bits of the product of the first two sources, adds the matching lane of the third, and writes the packed 128-bit result to the destination register.

Arithmetic wraps silently. The unit has no sign mode and sets no flags. The sources are read in the issue cycle. The result is registered and committed one clock later. A result that is still waiting to commit is forwarded, so back-to-back dependent instructions see it. The destination may be the same register as any source, which allows an in-place accumulate.

A load port lets a test environment preload registers. A combinational debug port reads the committed contents of any register.

Top module: `vmla_unit`

## Requirements
- R1: For each lane i, the result lane equals (A[i]*B[i] + C[i]) mod 2^16. Only the low 16 bits of the product are used, and an overflow wraps silently to the low 16 bits.
- R2: Lane 0 is bits 127:112 of every operand and of the result. Lane i occupies bits 127-16i down to 112-16i.
- R3: The result bits are the same whether the lanes are read as signed or unsigned values. For example, 0xFFFD*0x0005+0x0002 gives 0xFFF3.
- R4: The instruction fields use bit 31 as the most significant bit:
  - primary opcode in bits 31:26, which must equal 4
  - destination in bits 25:21
  - source A in bits 20:16
  - source B in bits 15:11
  - source C in bits 10:6
  - extended opcode in bits 5:0, which must equal 34
- R5: If either opcode field does not match, or issue_vld is low:
  - dec_hit is low in that cycle
  - no res_vld follows
  - no register changes
- R6: For a matching instruction with issue_vld high:
  - dec_hit is high in the same cycle
  - res_vld is high for exactly one cycle, in the next cycle
  - the result is visible on the debug port from the cycle after that
- R7: The destination may equal source A and/or source C. All sources use the register values from before the write.
- R8: An instruction issued in the cycle right after a matching instruction sees that instruction's result when it reads the same register.
- R9: A synchronous active-high reset clears all 32 registers to zero. A load-port write (ld_en high) stores ld_data into register ld_idx at the next clock edge.
- R10: dbg_data shows, combinationally, the committed contents of register dbg_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_vld | input | 1 | Instruction word is valid this cycle |
| issue_word | input | 32 | Instruction word |
| ld_en | input | 1 | Test-load write enable |
| ld_idx | input | 5 | Test-load register index |
| ld_data | input | 128 | Test-load data |
| dbg_idx | input | 5 | Debug read index |
| dbg_data | output | 128 | Committed contents of register dbg_idx |
| res_vld | output | 1 | One-cycle pulse when a result is written back |
| dec_hit | output | 1 | Instruction decoded as a match this cycle |

## Verification
A bad decode shows on dec_hit in the issue cycle and on res_vld one cycle later. A wrong lane, a wrong field slice or a wrong product width corrupts the destination, which the debug port shows two cycles after issue. A broken or missing forwarding path shows only when a dependent instruction follows immediately. Its wrong result appears on the debug port one cycle after the first result. Stale-operand faults in the aliased accumulate case show the same way at the destination register.

// File: rtl/vmla_unit.sv
module vmla_unit #(
  parameter int LANES = 8,
  parameter int LW    = 16,
  localparam int VW   = LANES * LW,
  localparam int NREG = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue_vld,
  input  logic [31:0]   issue_word,
  input  logic          ld_en,
  input  logic [4:0]    ld_idx,
  input  logic [VW-1:0] ld_data,
  input  logic [4:0]    dbg_idx,
  output logic [VW-1:0] dbg_data,
  output logic          res_vld,
  output logic          dec_hit
);

  logic [VW-1:0] rf [NREG];
  logic          wb_vld;
  logic [4:0]    wb_dst;
  logic [VW-1:0] wb_data;

  wire [5:0] f_op = issue_word[31:26];
  wire [4:0] f_d  = issue_word[25:21];
  wire [4:0] f_a  = issue_word[20:16];
  wire [4:0] f_b  = issue_word[15:11];
  wire [4:0] f_c  = issue_word[10:6];
  wire [5:0] f_xo = issue_word[5:0];

  assign dec_hit = issue_vld && (f_op == 6'd4) && (f_xo == 6'd34);

  wire [VW-1:0] op_a = (wb_vld && wb_dst == f_a) ? wb_data : rf[f_a];
  wire [VW-1:0] op_b = (wb_vld && wb_dst == f_b) ? wb_data : rf[f_b];
  wire [VW-1:0] op_c = (wb_vld && wb_dst == f_c) ? wb_data : rf[f_c];

  logic [VW-1:0] sum;
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int HI = VW - 1 - i * LW;
    wire [2*LW-1:0] prod = {{LW{1'b0}}, op_a[HI -: LW]} * {{LW{1'b0}}, op_b[HI -: LW]};
    assign sum[HI -: LW] = prod[LW-1:0] + op_c[HI -: LW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_vld  <= 1'b0;
      wb_dst  <= '0;
      wb_data <= '0;
      for (int k = 0; k < NREG; k++) rf[k] <= '0;
    end else begin
      wb_vld <= dec_hit;
      if (dec_hit) begin
        wb_dst  <= f_d;
        wb_data <= sum;
      end
      if (wb_vld) rf[wb_dst] <= wb_data;
      if (ld_en)  rf[ld_idx] <= ld_data;
    end
  end

  assign res_vld  = wb_vld;
  assign dbg_data = rf[dbg_idx];

endmodule

// File: rtl/vmla_unit_chk.sv
module vmla_unit_chk #(
  parameter int VW = 128
) (
  input logic          clk,
  input logic          rst,
  input logic          issue_vld,
  input logic          dec_hit,
  input logic          res_vld,
  input logic          ld_en,
  input logic [4:0]    dbg_idx,
  input logic [VW-1:0] dbg_data
);

  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst) dec_hit |-> issue_vld); // R5
  AST_MISS_NO_RESULT: assert property (@(posedge clk) disable iff (rst) !dec_hit |=> !res_vld); // R5
  AST_HIT_GIVES_RESULT: assert property (@(posedge clk) disable iff (rst) dec_hit |=> res_vld); // R6
  AST_RF_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!res_vld && !ld_en) |=> (!$stable(dbg_idx) || $stable(dbg_data))); // R5

endmodule

bind vmla_unit vmla_unit_chk #(.VW(VW)) u_chk (
  .clk(clk), .rst(rst), .issue_vld(issue_vld), .dec_hit(dec_hit),
  .res_vld(res_vld), .ld_en(ld_en), .dbg_idx(dbg_idx), .dbg_data(dbg_data)
);

// File: tb/vmla_unit_bench.sv
`timescale 1ns/1ps
module vmla_unit_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         issue_vld = 1'b0;
  logic [31:0]  issue_word = '0;
  logic         ld_en = 1'b0;
  logic [4:0]   ld_idx = '0;
  logic [127:0] ld_data = '0;
  logic [4:0]   dbg_idx = '0;
  logic [127:0] dbg_data;
  logic         res_vld;
  logic         dec_hit;

  int n_chk = 0;
  int n_bad = 0;
  logic [127:0] mdl [32];

  always #4 clk = ~clk;

  vmla_unit u_vmla_unit (
    .clk(clk), .rst(rst), .issue_vld(issue_vld), .issue_word(issue_word),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data), .dbg_idx(dbg_idx),
    .dbg_data(dbg_data), .res_vld(res_vld), .dec_hit(dec_hit)
  );

  function automatic logic [31:0] enc(input logic [4:0] d, a, b, c);
    return {6'd4, d, a, b, c, 6'd34};
  endfunction

  function automatic logic [127:0] mla(input logic [127:0] a, b, c);
    logic [127:0] r;
    for (int i = 0; i < 8; i++) begin
      logic [31:0] p;
      p = {16'd0, a[127-16*i -: 16]} * {16'd0, b[127-16*i -: 16]};
      r[127-16*i -: 16] = p[15:0] + c[127-16*i -: 16];
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [4:0] idx, input string req);
    dbg_idx = idx;
    #1;
    chk(dbg_data === mdl[idx], req, dbg_data, mdl[idx]);
  endtask

  task automatic load(input logic [4:0] idx, input logic [127:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = idx; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
    mdl[idx] = d;
  endtask

  task automatic issue_one(input logic [31:0] w, input bit hit, input string req);
    @(negedge clk);
    issue_vld = 1'b1; issue_word = w;
    #1;
    chk(dec_hit === hit, req, 128'(dec_hit), 128'(hit));
    if (hit) mdl[w[25:21]] = mla(mdl[w[20:16]], mdl[w[15:11]], mdl[w[10:6]]);
    @(negedge clk);
    issue_vld = 1'b0;
    chk(res_vld === hit, req, 128'(res_vld), 128'(hit));
    @(negedge clk);
    chk(res_vld === 1'b0, "R6 single pulse", 128'(res_vld), 128'd0);
  endtask

  task automatic t_reset;
    for (int k = 0; k < 32; k++) begin
      mdl[k] = '0;
      rd_chk(k[4:0], "R9 reset clear");
    end
    chk(res_vld === 1'b0 && dec_hit === 1'b0, "R9 reset outputs", 128'({res_vld, dec_hit}), 128'd0);
  endtask

  task automatic t_basic;
    load(5'd1, 128'h0001_0002_0003_0004_0005_0006_0007_0008);
    load(5'd2, 128'h0010_0020_0030_0040_0050_0060_0070_0080);
    load(5'd3, 128'h0100_0200_0300_0400_0500_0600_0700_0800);
    rd_chk(5'd2, "R9 load port");
    issue_one(enc(5'd4, 5'd1, 5'd2, 5'd3), 1'b1, "R6 hit timing");
    rd_chk(5'd4, "R1 basic lanes");
    chk(dbg_data[127:112] === 16'h0110, "R2 lane0 msb", 128'(dbg_data[127:112]), 128'h0110);
    chk(dbg_data[15:0] === 16'h0C00, "R2 lane7 lsb", 128'(dbg_data[15:0]), 128'h0C00);
  endtask

  task automatic t_wrap;
    load(5'd8, {8{16'hFFFF}});
    load(5'd9, {8{16'h1234}});
    issue_one(enc(5'd10, 5'd8, 5'd8, 5'd8), 1'b1, "R6 hit");
    rd_chk(5'd10, "R1 wrap all ones");
    chk(dbg_data === '0, "R1 wrap to zero", dbg_data, '0);
    issue_one(enc(5'd11, 5'd9, 5'd9, 5'd8), 1'b1, "R6 hit");
    rd_chk(5'd11, "R1 product truncation");
  endtask

  task automatic t_signed;
    load(5'd12, {8{16'hFFFD}});
    load(5'd13, {8{16'h0005}});
    load(5'd14, {8{16'h0002}});
    issue_one(enc(5'd15, 5'd12, 5'd13, 5'd14), 1'b1, "R6 hit");
    dbg_idx = 5'd15; #1;
    chk(dbg_data === {8{16'hFFF3}}, "R3 signed unsigned same", dbg_data, {8{16'hFFF3}});
  endtask

  task automatic t_fields;
    load(5'd17, 128'h1111_2222_3333_4444_5555_6666_7777_8888);
    load(5'd8,  128'h0003_0005_0007_0009_000B_000D_000F_0011);
    load(5'd30, 128'hA000_B000_C000_D000_E000_F000_0100_0200);
    issue_one(enc(5'd31, 5'd17, 5'd8, 5'd30), 1'b1, "R4 fields");
    rd_chk(5'd31, "R4 field positions");
    rd_chk(5'd17, "R4 source untouched");
  endtask

  task automatic t_bad;
    logic [31:0] w;
    w = enc(5'd20, 5'd1, 5'd2, 5'd3);
    w[31:26] = 6'd5;
    issue_one(w, 1'b0, "R5 bad primary");
    rd_chk(5'd20, "R5 rf unchanged primary");
    w = enc(5'd20, 5'd1, 5'd2, 5'd3);
    w[5:0] = 6'd35;
    issue_one(w, 1'b0, "R5 bad extended");
    rd_chk(5'd20, "R5 rf unchanged extended");
    @(negedge clk);
    issue_word = enc(5'd20, 5'd1, 5'd2, 5'd3); issue_vld = 1'b0;
    #1;
    chk(dec_hit === 1'b0, "R5 valid low", 128'(dec_hit), 128'd0);
    @(negedge clk);
    chk(res_vld === 1'b0, "R5 no result", 128'(res_vld), 128'd0);
    rd_chk(5'd20, "R5 rf unchanged invalid");
  endtask

  task automatic t_alias;
    load(5'd5, 128'h0001_0002_0003_0004_0100_0200_FFFF_8000);
    load(5'd6, 128'h0002_0003_0004_0005_0006_0007_0008_0009);
    issue_one(enc(5'd5, 5'd5, 5'd6, 5'd5), 1'b1, "R7 hit");
    rd_chk(5'd5, "R7 accumulate alias");
  endtask

  task automatic t_b2b;
    logic [127:0] r1, r2;
    r1 = mla(mdl[1], mdl[2], mdl[3]);
    r2 = mla(r1, mdl[2], r1);
    @(negedge clk);
    issue_vld = 1'b1; issue_word = enc(5'd21, 5'd1, 5'd2, 5'd3);
    @(negedge clk);
    issue_word = enc(5'd22, 5'd21, 5'd2, 5'd21);
    chk(res_vld === 1'b1, "R8 first result", 128'(res_vld), 128'd1);
    @(negedge clk);
    issue_vld = 1'b0;
    chk(res_vld === 1'b1, "R8 second result", 128'(res_vld), 128'd1);
    @(negedge clk);
    mdl[21] = r1; mdl[22] = r2;
    rd_chk(5'd21, "R8 first dest");
    rd_chk(5'd22, "R8 forwarded dest");
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_wrap();
    t_signed();
    t_fields();
    t_bad();
    t_alias();
    t_b2b();
    rd_chk(5'd0, "R10 debug untouched reg");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule